// File: doc/BRIEF.md
# Descriptor-List Stream DMA Sequencer

This block runs the data side of a set of audio streams. Half of the streams carry input (codec to memory) and half carry output (memory to codec). Software configures each stream through a small write port: a control word, the length of the cyclic buffer, the index of the last valid descriptor and the base address of the descriptor list. When the run bit of a stream goes from 0 to 1, the block fetches that stream's descriptor list from memory into local storage.

A codec asks for bytes by presenting a stream tag, a direction and a byte count. The block picks the matching stream and splits the request into memory data commands. Each command is clipped at the end of the cyclic buffer and at the end of the current descriptor. The block then advances its link position and its place in the descriptor list.

When a descriptor that asks for a completion event is used up, the block sets a completion flag in the stream's control word. Transfers on that stream stop until software clears the flag. If position write-back is enabled, the block writes the link position to a table in memory after each served request. Sample formats and FIFO sizing belong to other blocks.

Top module: `bdl_stream_dma`

## Requirements
- R1: A 0-to-1 change of the run bit (control bit 1) marks the stream for a descriptor load. For descriptor k and word w (w = 0 address low, 1 address high, 2 byte length, 3 flags; flag bit 0 asks for a completion event), the block reads 32-bit words at list base + 16·k + 4·w, in increasing k and then w. It reads last-valid-index + 1 descriptors. This is done before any codec request is served. Writes to the low half of the list base ignore bits 6:0.
- R2: A control write keeps bits 0–4 and 16–23 from the written value. A 1 written to any of bits 26–28 clears that bit, and a 0 leaves it unchanged. Software can never set bits 26–28. After reset every control word reads 0.
- R3: The 4-bit stream tag sits in control bits 23:20. An output request (direction 1) searches streams SPD..2·SPD−1 and an input request searches streams 0..SPD−1. The lowest-numbered stream whose tag matches wins. A request with no match completes with 0 bytes and makes no memory access.
- R4: Each data command (kind 1) moves min(bytes still requested, cyclic length − link position, descriptor length − offset in descriptor) bytes. It uses address = descriptor address + offset and memory write = 1 for input streams. A chunk size of 0 ends the request.
- R5: When the link position reaches the cyclic length, it becomes 0. When a descriptor is used up, the offset returns to 0 and the index moves to the next descriptor, or to 0 after the last one.
- R6: If a descriptor with flag bit 0 was used up during a request, control bit 26 is set when the request ends. While bit 26 is set, requests to that stream complete with 0 bytes and make no memory access.
- R7: If bit 0 of the position-table base is 1, each request that moved data or could have moved data ends with a write (kind 2). The write puts the stream's link position at (base with bit 0 cleared) + 8·stream.
- R8: While control bit 0 (stream reset) is 1, the link position, descriptor index and offset clear to 0 on the following clock.
- R9: A request matched to a stream whose run bit is 0 completes with 0 bytes and makes no memory access.
- R10: A memory command holds its request, kind, address and length steady until it is acknowledged. Kind 0 is a descriptor read of length 4.
- R11: Completion of each codec request is a one-cycle pulse. The byte count presented with it is the total moved for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_stream | input | SW | Stream addressed by the write |
| cfg_field | input | 3 | 0 control, 1 cyclic length, 2 last valid index, 3 list base low, 4 list base high |
| cfg_wdata | input | 32 | Write data |
| pos_base | input | ADDR_W | Position table base; bit 0 enables write-back |
| xfer_req | input | 1 | Codec request, held until completion |
| xfer_tag | input | 4 | Requested stream tag |
| xfer_out | input | 1 | 1 = output direction |
| xfer_len | input | 32 | Requested byte count |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_moved | output | 32 | Bytes moved, valid with xfer_done |
| mem_req | output | 1 | Memory command valid |
| mem_kind | output | 2 | 0 descriptor read, 1 data, 2 position write |
| mem_we | output | 1 | 1 = write to memory |
| mem_addr | output | ADDR_W | Byte address |
| mem_len | output | 32 | Byte count of the command |
| mem_wdata | output | 32 | Write data for position writes |
| mem_ack | input | 1 | Command accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| st_ctl | output | 32·NS | Control words, stream 0 in the low bits |
| st_lpib | output | 32·NS | Link positions, stream 0 in the low bits |

## Verification
The assertions assume that register writes and a change of the position-table base happen only while no codec request or descriptor load is in progress. They also assume that a codec request is held until its completion pulse and dropped right after it. The clipping and wrap properties further assume that a running stream's cyclic length is not below its link position. The bench meets all of this: it writes registers only between requests and waits for the load commands to drain. It lowers the request on the same falling edge that observes completion, and it never shrinks a buffer behind its position. Its memory model delays every acknowledge by one cycle so that command stability is actually observed.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam logic [31:0] CTL_RW_MASK  = 32'h00FF_001F;
  localparam logic [31:0] CTL_W1C_MASK = 32'h1C00_0000;
  localparam int CMPL_BIT = 26;
  localparam int RUN_BIT  = 1;
  localparam int SRST_BIT = 0;
  localparam int TAG_LSB  = 20;

  typedef enum logic [2:0] {
    FLD_CTL = 3'd0, FLD_CBL = 3'd1, FLD_LVI = 3'd2, FLD_BASE_LO = 3'd3, FLD_BASE_HI = 3'd4
  } cfg_field_e;

  typedef enum logic [1:0] {MK_DESC = 2'd0, MK_DATA = 2'd1, MK_POS = 2'd2} mem_kind_e;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_CHUNK, S_POS, S_DONE} seq_state_e;

  // bytes left before a limit, zero when already at or past it
  function automatic logic [31:0] room_left(input logic [31:0] limit, input logic [31:0] used);
    return (used >= limit) ? 32'd0 : limit - used;
  endfunction

  function automatic logic [31:0] min3(input logic [31:0] a, input logic [31:0] b,
                                      input logic [31:0] c);
    logic [31:0] m;
    m = (a < b) ? a : b;
    return (c < m) ? c : m;
  endfunction

  // control write: masked update, then write-one-to-clear on status bits
  function automatic logic [31:0] ctl_next(input logic [31:0] old, input logic [31:0] wd);
    logic [31:0] n;
    n = (old & ~CTL_RW_MASK) | (wd & CTL_RW_MASK);
    return n & ~(wd & CTL_W1C_MASK);
  endfunction
endpackage

// File: rtl/sdma_ctx.sv
module sdma_ctx
  import bsd_pkg::*;
#(
  parameter int MAX_DESC = 4,
  parameter int ADDR_W   = 64,
  localparam int IW      = $clog2(MAX_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_field,
  input  logic [31:0]       cfg_wdata,
  input  logic              eng_upd,
  input  logic [31:0]       upd_lpib,
  input  logic [IW-1:0]     upd_be,
  input  logic [31:0]       upd_bp,
  input  logic              eng_cmpl,
  input  logic              dwr_en,
  input  logic [IW-1:0]     dwr_k,
  input  logic [1:0]        dwr_w,
  input  logic [31:0]       dwr_data,
  input  logic              load_clr,
  output logic [31:0]       ctl,
  output logic [31:0]       cbl,
  output logic [ADDR_W-1:0] base,
  output logic [31:0]       lpib,
  output logic [IW-1:0]     be,
  output logic [31:0]       bp,
  output logic [IW:0]       nent,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [31:0]       cur_len,
  output logic              cur_ioc,
  output logic              load_pend
);
  logic [IW-1:0]     lvi_q;
  logic [ADDR_W-1:0] d_addr [MAX_DESC];
  logic [31:0]       d_len  [MAX_DESC];
  logic              d_ioc  [MAX_DESC];
  logic [31:0]       ctl_wr;
  logic              ctl_hit, run_rise;

  assign ctl_hit  = cfg_we && (cfg_field == FLD_CTL);
  assign ctl_wr   = ctl_next(ctl, cfg_wdata);
  assign run_rise = ctl_hit && !ctl[RUN_BIT] && ctl_wr[RUN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0; cbl <= '0; lvi_q <= '0; base <= '0; load_pend <= 1'b0;
    end else begin
      if (ctl_hit) ctl <= ctl_wr | (32'(eng_cmpl) << CMPL_BIT);
      else if (eng_cmpl) ctl[CMPL_BIT] <= 1'b1;
      if (cfg_we && cfg_field == FLD_CBL) cbl <= cfg_wdata;
      if (cfg_we && cfg_field == FLD_LVI) lvi_q <= cfg_wdata[IW-1:0];
      if (cfg_we && cfg_field == FLD_BASE_LO) base[31:0] <= {cfg_wdata[31:7], 7'd0};
      if (cfg_we && cfg_field == FLD_BASE_HI) base[ADDR_W-1:32] <= cfg_wdata[ADDR_W-33:0];
      if (run_rise) load_pend <= 1'b1;
      else if (load_clr) load_pend <= 1'b0;
    end
  end

  // position state: stream reset has priority over engine updates
  always_ff @(posedge clk) begin
    if (!rst_n || ctl[SRST_BIT]) begin
      lpib <= '0; be <= '0; bp <= '0;
    end else if (eng_upd) begin
      lpib <= upd_lpib; be <= upd_be; bp <= upd_bp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < MAX_DESC; k++) begin
        d_addr[k] <= '0; d_len[k] <= '0; d_ioc[k] <= 1'b0;
      end
    end else if (dwr_en) begin
      unique case (dwr_w)
        2'd0: d_addr[dwr_k][31:0] <= dwr_data;
        2'd1: d_addr[dwr_k][ADDR_W-1:32] <= dwr_data[ADDR_W-33:0];
        2'd2: d_len[dwr_k] <= dwr_data;
        default: d_ioc[dwr_k] <= dwr_data[0];
      endcase
    end
  end

  assign nent     = {1'b0, lvi_q} + 1'b1;
  assign cur_addr = d_addr[be];
  assign cur_len  = d_len[be];
  assign cur_ioc  = d_ioc[be];

  p_load_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[RUN_BIT]) |-> load_pend);
  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && cfg_wdata[CMPL_BIT] && !eng_cmpl) |=> !ctl[CMPL_BIT]);
  p_lpib_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_upd && !ctl[SRST_BIT]) |=> (lpib < cbl));
  p_srst_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[SRST_BIT] |=> (lpib == 32'd0 && be == '0 && bp == 32'd0));
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import bsd_pkg::*;
#(
  parameter int SPD      = 4,
  parameter int MAX_DESC = 4,
  parameter int ADDR_W   = 64,
  localparam int NS      = 2 * SPD,
  localparam int SW      = $clog2(NS),
  localparam int IW      = $clog2(MAX_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_v  [NS],
  input  logic              cmpl_v [NS],
  input  logic [3:0]        tag_v  [NS],
  input  logic              pend_v [NS],
  input  logic [31:0]       v_cbl,
  input  logic [31:0]       v_lpib,
  input  logic [IW-1:0]     v_be,
  input  logic [31:0]       v_bp,
  input  logic [IW:0]       v_nent,
  input  logic [ADDR_W-1:0] v_base,
  input  logic [ADDR_W-1:0] v_daddr,
  input  logic [31:0]       v_dlen,
  input  logic              v_dioc,
  input  logic              xfer_req,
  input  logic [3:0]        xfer_tag,
  input  logic              xfer_out,
  input  logic [31:0]       xfer_len,
  output logic              xfer_done,
  output logic [31:0]       xfer_moved,
  input  logic [ADDR_W-1:0] pos_base,
  output logic              mem_req,
  output logic [1:0]        mem_kind,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_len,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [SW-1:0]     sel,
  output logic              eng_upd,
  output logic [31:0]       upd_lpib,
  output logic [IW-1:0]     upd_be,
  output logic [31:0]       upd_bp,
  output logic              eng_cmpl,
  output logic              dwr_en,
  output logic [IW-1:0]     dwr_k,
  output logic [1:0]        dwr_w,
  output logic [31:0]       dwr_data,
  output logic              load_clr
);
  seq_state_e  st;
  logic [IW:0] k_q;
  logic [1:0]  w_q;
  logic [31:0] left_q;
  logic        dir_q, irq_q;
  logic        hit, any_pend;
  logic [SW-1:0] hit_idx, pend_idx;
  logic [31:0] copy, bp_sum, lp_sum;
  logic        go, consumed, last_word;

  always_comb begin
    int grp;
    grp = xfer_out ? SPD : 0;
    hit = 1'b0; hit_idx = '0;
    for (int i = SPD - 1; i >= 0; i--)
      if (tag_v[grp + i] == xfer_tag) begin hit = 1'b1; hit_idx = SW'(grp + i); end
    any_pend = 1'b0; pend_idx = '0;
    for (int i = NS - 1; i >= 0; i--)
      if (pend_v[i]) begin any_pend = 1'b1; pend_idx = SW'(i); end
  end

  // chunk arithmetic for the selected stream
  assign copy      = min3(left_q, room_left(v_cbl, v_lpib), room_left(v_dlen, v_bp));
  assign go        = (copy != 32'd0);
  assign bp_sum    = v_bp + copy;
  assign lp_sum    = v_lpib + copy;
  assign consumed  = (bp_sum == v_dlen);
  assign upd_bp    = consumed ? 32'd0 : bp_sum;
  assign upd_lpib  = (lp_sum == v_cbl) ? 32'd0 : lp_sum;
  assign upd_be    = !consumed ? v_be :
                     ({1'b0, v_be} == v_nent - 1'b1) ? '0 : v_be + 1'b1;
  assign last_word = (w_q == 2'd3) && (k_q == v_nent - 1'b1);

  assign eng_upd   = (st == S_CHUNK) && go && mem_ack;
  assign eng_cmpl  = (st == S_CHUNK) && !go && irq_q;
  assign dwr_en    = (st == S_LOAD) && mem_ack;
  assign dwr_k     = k_q[IW-1:0];
  assign dwr_w     = w_q;
  assign dwr_data  = mem_rdata;
  assign load_clr  = dwr_en && last_word;
  assign xfer_done = (st == S_DONE);

  always_comb begin
    mem_req = 1'b0; mem_kind = MK_DESC; mem_we = 1'b0;
    mem_addr = '0; mem_len = 32'd4; mem_wdata = '0;
    unique case (st)
      S_LOAD: begin
        mem_req  = 1'b1;
        mem_addr = v_base + (ADDR_W'(k_q) << 4) + (ADDR_W'(w_q) << 2);
      end
      S_CHUNK: begin
        mem_req = go; mem_kind = MK_DATA; mem_we = !dir_q;
        mem_addr = v_daddr + ADDR_W'(v_bp); mem_len = copy;
      end
      S_POS: begin
        mem_req = pos_base[0]; mem_kind = MK_POS; mem_we = 1'b1;
        mem_addr = {pos_base[ADDR_W-1:1], 1'b0} + (ADDR_W'(sel) << 3);
        mem_wdata = v_lpib;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; sel <= '0; k_q <= '0; w_q <= '0;
      left_q <= '0; xfer_moved <= '0; irq_q <= 1'b0; dir_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE:
          if (any_pend) begin
            sel <= pend_idx; k_q <= '0; w_q <= '0; st <= S_LOAD;
          end else if (xfer_req) begin
            xfer_moved <= '0; irq_q <= 1'b0;
            if (hit && run_v[hit_idx] && !cmpl_v[hit_idx]) begin
              sel <= hit_idx; left_q <= xfer_len; dir_q <= xfer_out; st <= S_CHUNK;
            end else st <= S_DONE;
          end
        S_LOAD:
          if (mem_ack) begin
            w_q <= w_q + 2'd1;
            if (w_q == 2'd3) begin
              if (last_word) st <= S_IDLE;
              else k_q <= k_q + 1'b1;
            end
          end
        S_CHUNK:
          if (!go) st <= S_POS;
          else if (mem_ack) begin
            left_q     <= left_q - copy;
            xfer_moved <= xfer_moved + copy;
            if (consumed && v_dioc) irq_q <= 1'b1;
          end
        S_POS:   if (!pos_base[0] || mem_ack) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_chunk_clip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_kind == MK_DATA) |->
      (mem_len != 0 && mem_len <= left_q && v_lpib + mem_len <= v_cbl && v_bp + mem_len <= v_dlen));
  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_kind == MK_DATA) |-> !cmpl_v[sel]);
  p_run_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_kind == MK_DATA) |-> run_v[sel]);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_kind)));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
endmodule

// File: rtl/bdl_stream_dma.sv
module bdl_stream_dma
  import bsd_pkg::*;
#(
  parameter int SPD      = 4,
  parameter int MAX_DESC = 4,
  parameter int ADDR_W   = 64,
  localparam int NS      = 2 * SPD,
  localparam int SW      = $clog2(NS),
  localparam int IW      = $clog2(MAX_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SW-1:0]     cfg_stream,
  input  logic [2:0]        cfg_field,
  input  logic [31:0]       cfg_wdata,
  input  logic [ADDR_W-1:0] pos_base,
  input  logic              xfer_req,
  input  logic [3:0]        xfer_tag,
  input  logic              xfer_out,
  input  logic [31:0]       xfer_len,
  output logic              xfer_done,
  output logic [31:0]       xfer_moved,
  output logic              mem_req,
  output logic [1:0]        mem_kind,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_len,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [32*NS-1:0]  st_ctl,
  output logic [32*NS-1:0]  st_lpib
);
  logic [31:0]       ctl_a [NS], cbl_a [NS], lpib_a [NS], bp_a [NS], dlen_a [NS];
  logic [ADDR_W-1:0] base_a [NS], daddr_a [NS];
  logic [IW-1:0]     be_a [NS];
  logic [IW:0]       nent_a [NS];
  logic              dioc_a [NS], pend_a [NS], run_a [NS], cmpl_a [NS];
  logic [3:0]        tag_a [NS];

  logic [SW-1:0] sel;
  logic          eng_upd, eng_cmpl, dwr_en, load_clr;
  logic [31:0]   upd_lpib, upd_bp, dwr_data;
  logic [IW-1:0] upd_be, dwr_k;
  logic [1:0]    dwr_w;

  for (genvar s = 0; s < NS; s++) begin : g_ctx
    sdma_ctx #(.MAX_DESC(MAX_DESC), .ADDR_W(ADDR_W)) u_ctx (
      .clk, .rst_n,
      .cfg_we   (cfg_we && cfg_stream == SW'(s)),
      .cfg_field, .cfg_wdata,
      .eng_upd  (eng_upd && sel == SW'(s)),
      .upd_lpib, .upd_be, .upd_bp,
      .eng_cmpl (eng_cmpl && sel == SW'(s)),
      .dwr_en   (dwr_en && sel == SW'(s)),
      .dwr_k, .dwr_w, .dwr_data,
      .load_clr (load_clr && sel == SW'(s)),
      .ctl (ctl_a[s]), .cbl (cbl_a[s]), .base (base_a[s]), .lpib (lpib_a[s]),
      .be (be_a[s]), .bp (bp_a[s]), .nent (nent_a[s]), .cur_addr (daddr_a[s]),
      .cur_len (dlen_a[s]), .cur_ioc (dioc_a[s]), .load_pend (pend_a[s])
    );
    assign run_a[s]  = ctl_a[s][RUN_BIT];
    assign cmpl_a[s] = ctl_a[s][CMPL_BIT];
    assign tag_a[s]  = ctl_a[s][TAG_LSB +: 4];
    assign st_ctl[32*s +: 32]  = ctl_a[s];
    assign st_lpib[32*s +: 32] = lpib_a[s];
  end

  sdma_seq #(.SPD(SPD), .MAX_DESC(MAX_DESC), .ADDR_W(ADDR_W)) u_seq (
    .clk, .rst_n,
    .run_v (run_a), .cmpl_v (cmpl_a), .tag_v (tag_a), .pend_v (pend_a),
    .v_cbl (cbl_a[sel]), .v_lpib (lpib_a[sel]), .v_be (be_a[sel]), .v_bp (bp_a[sel]),
    .v_nent (nent_a[sel]), .v_base (base_a[sel]), .v_daddr (daddr_a[sel]),
    .v_dlen (dlen_a[sel]), .v_dioc (dioc_a[sel]),
    .xfer_req, .xfer_tag, .xfer_out, .xfer_len, .xfer_done, .xfer_moved,
    .pos_base, .mem_req, .mem_kind, .mem_we, .mem_addr, .mem_len, .mem_wdata,
    .mem_ack, .mem_rdata,
    .sel, .eng_upd, .upd_lpib, .upd_be, .upd_bp, .eng_cmpl,
    .dwr_en, .dwr_k, .dwr_w, .dwr_data, .load_clr
  );
endmodule

// File: tb/sim_bdl_stream_dma.sv
module sim_bdl_stream_dma;
  localparam int SPD = 4, NS = 8, ND = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [2:0] cfg_stream = 0; logic [2:0] cfg_field = 0; logic [31:0] cfg_wdata = 0;
  logic [63:0] pos_base = 0;
  logic xfer_req = 0, xfer_out = 0; logic [3:0] xfer_tag = 0; logic [31:0] xfer_len = 0;
  logic xfer_done; logic [31:0] xfer_moved;
  logic mem_req, mem_we, mem_ack = 0; logic [1:0] mem_kind;
  logic [63:0] mem_addr; logic [31:0] mem_len, mem_wdata, mem_rdata = 0;
  logic [32*NS-1:0] st_ctl, st_lpib;

  always #4 clk = ~clk;

  bdl_stream_dma u0 (.*);

  int checks = 0, errors = 0;
  bit quiet = 0;

  typedef struct { int kind; bit we; logic [63:0] addr; int unsigned len; logic [31:0] wd; } req_t;
  req_t expq[$];
  logic [31:0] mw [longint unsigned];

  logic [31:0] m_ctl [NS]; int unsigned m_cbl [NS], m_lpib [NS], m_bp [NS];
  int m_be [NS], m_lvi [NS]; logic [63:0] m_base [NS];
  logic [63:0] m_da [NS][ND]; int unsigned m_dl [NS][ND]; bit m_di [NS][ND]; int m_n [NS];

  task automatic check(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp); end
  endtask

  function automatic logic [31:0] rd(logic [63:0] a);
    return mw.exists(a) ? mw[a] : 32'h0;
  endfunction

  task automatic put_desc(logic [63:0] b, int k, logic [63:0] a, int unsigned l, logic [31:0] f);
    mw[b + 16*k] = a[31:0]; mw[b + 16*k + 4] = a[63:32]; mw[b + 16*k + 8] = l; mw[b + 16*k + 12] = f;
  endtask

  task automatic push_req(int kind, bit we, logic [63:0] a, int unsigned l, logic [31:0] wd);
    req_t r; r.kind = kind; r.we = we; r.addr = a; r.len = l; r.wd = wd; expq.push_back(r);
  endtask

  // memory model: acknowledges each command one cycle after first seeing it
  initial begin
    bit pend = 0; logic [63:0] cap_a; logic [31:0] cap_l;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        if (!pend) begin pend = 1; cap_a = mem_addr; cap_l = mem_len; end
        else begin
          req_t e; string rq;
          pend = 0;
          check(mem_addr == cap_a && mem_len == cap_l, "R10", "command held", mem_addr, cap_a);
          if (expq.size() == 0) check(0, "R3", "unexpected memory command", mem_addr, 0);
          else begin
            e = expq.pop_front();
            rq = (e.kind == 0) ? "R1" : (e.kind == 1) ? "R4" : "R7";
            check(mem_kind == 2'(e.kind), rq, "kind", mem_kind, e.kind);
            check(mem_addr == e.addr, rq, "address", mem_addr, e.addr);
            check(mem_len == e.len, rq, "length", mem_len, e.len);
            check(mem_we == e.we, rq, "direction", mem_we, e.we);
            if (e.kind == 2) check(mem_wdata == e.wd, "R7", "position value", mem_wdata, e.wd);
          end
          mem_rdata = rd(mem_addr);
          mem_ack = 1;
        end
      end
    end
  end

  // per-clock comparison of visible state while the block is quiet
  always @(negedge clk) if (rst_n && quiet) begin
    for (int s = 0; s < NS; s++) begin
      check(st_ctl[32*s +: 32] == m_ctl[s], "R2", $sformatf("ctl stream %0d", s), st_ctl[32*s +: 32], m_ctl[s]);
      check(st_lpib[32*s +: 32] == m_lpib[s], "R5", $sformatf("position stream %0d", s), st_lpib[32*s +: 32], m_lpib[s]);
    end
  end

  task automatic cfg_write(int s, int f, logic [31:0] d);
    quiet = 0;
    @(negedge clk);
    cfg_we = 1; cfg_stream = 3'(s); cfg_field = 3'(f); cfg_wdata = d;
    case (f)
      0: begin
        logic [31:0] o, n;
        o = m_ctl[s];
        n = (o & ~32'h00FF001F) | (d & 32'h00FF001F);
        n = n & ~(d & 32'h1C000000);
        if (!o[1] && n[1]) begin
          m_n[s] = m_lvi[s] + 1;
          for (int k = 0; k < m_n[s]; k++) begin
            logic [63:0] b; b = m_base[s] + 16*k;
            for (int w = 0; w < 4; w++) push_req(0, 0, b + 4*w, 4, 0);
            m_da[s][k] = {rd(b + 4), rd(b)}; m_dl[s][k] = rd(b + 8); m_di[s][k] = rd(b + 12) & 1;
          end
        end
        if (n[0]) begin m_lpib[s] = 0; m_be[s] = 0; m_bp[s] = 0; end
        m_ctl[s] = n;
      end
      1: m_cbl[s] = d;
      2: m_lvi[s] = d & 3;
      3: m_base[s][31:0] = d & 32'hFFFFFF80;
      default: m_base[s][63:32] = d;
    endcase
    @(negedge clk);
    cfg_we = 0;
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
    quiet = 1;
  endtask

  task automatic do_xfer(int tag, bit out, int unsigned len, string rq);
    int s = -1; int unsigned left = len, moved = 0; bit irq = 0;
    for (int i = 0; i < SPD; i++)
      if (s < 0 && m_ctl[(out ? SPD : 0) + i][23:20] == 4'(tag)) s = (out ? SPD : 0) + i;
    if (s >= 0 && m_ctl[s][1] && !m_ctl[s][26]) begin
      while (left > 0) begin
        int unsigned c = left, rm;
        rm = (m_cbl[s] > m_lpib[s]) ? m_cbl[s] - m_lpib[s] : 0; if (rm < c) c = rm;
        rm = (m_dl[s][m_be[s]] > m_bp[s]) ? m_dl[s][m_be[s]] - m_bp[s] : 0; if (rm < c) c = rm;
        if (c == 0) break;
        push_req(1, !out, m_da[s][m_be[s]] + m_bp[s], c, 0);
        left -= c; moved += c; m_lpib[s] += c; m_bp[s] += c;
        if (m_bp[s] == m_dl[s][m_be[s]]) begin
          if (m_di[s][m_be[s]]) irq = 1;
          m_bp[s] = 0; m_be[s] = (m_be[s] + 1) % m_n[s];
        end
        if (m_lpib[s] == m_cbl[s]) m_lpib[s] = 0;
      end
      if (irq) m_ctl[s][26] = 1;
      if (pos_base[0]) push_req(2, 1, {pos_base[63:1], 1'b0} + 8*s, 4, m_lpib[s]);
    end
    quiet = 0;
    @(negedge clk);
    xfer_req = 1; xfer_tag = 4'(tag); xfer_out = out; xfer_len = len;
    do @(negedge clk); while (!xfer_done);
    check(xfer_moved == moved, rq, "bytes moved", xfer_moved, moved);
    check(expq.size() == 0, rq, "all commands issued", expq.size(), 0);
    expq.delete();
    xfer_req = 0;
    @(negedge clk);
    check(!xfer_done, "R11", "completion is a single pulse", xfer_done, 0);
    quiet = 1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++; $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_ctl[s] = 0; m_cbl[s] = 0; m_lpib[s] = 0; m_bp[s] = 0; m_be[s] = 0; m_lvi[s] = 0; m_base[s] = 0; m_n[s] = 1;
      for (int k = 0; k < ND; k++) begin m_da[s][k] = 0; m_dl[s][k] = 0; m_di[s][k] = 0; end
    end
    put_desc(64'h1000, 0, 64'h1_0001_0000, 64, 0);
    put_desc(64'h1000, 1, 64'h20000, 32, 1);
    put_desc(64'h1000, 2, 64'h30000, 48, 0);
    put_desc(64'h2000, 0, 64'h40000, 40, 1);
    put_desc(64'h2000, 1, 64'h50000, 40, 1);
    put_desc(64'h2100, 0, 64'h60000, 80, 0);
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(st_ctl == '0 && st_lpib == '0, "R2", "reset state of stream registers", st_ctl[31:0], 0);
    check(!mem_req && !xfer_done, "R10", "idle memory port after reset", mem_req, 0);
    quiet = 1;

    // output stream 4: 3 descriptors, cyclic length 144, tag 5 (R1)
    cfg_write(4, 1, 144); cfg_write(4, 2, 2); cfg_write(4, 3, 32'h1000 | 32'h55); cfg_write(4, 4, 0);
    cfg_write(4, 0, 32'h0050_0002);
    do_xfer(5, 1, 50, "R4");            // single chunk inside descriptor 0
    do_xfer(5, 1, 30, "R4");            // split at descriptor boundary
    do_xfer(5, 1, 40, "R6");            // flagged descriptor used up
    do_xfer(5, 1, 10, "R6");            // stalled: no bytes
    cfg_write(4, 0, 32'h0050_0002);     // writing 0 to bit 26 keeps it (R2)
    cfg_write(4, 0, 32'h0450_0002);     // write-one-to-clear (R2)
    pos_base = 64'h8001;
    do_xfer(5, 1, 100, "R5");           // buffer and list wrap, position write (R7)
    // input streams 0 and 1 share tag 5; stream 0 must win (R3)
    cfg_write(1, 1, 80); cfg_write(1, 2, 0); cfg_write(1, 3, 32'h2100); cfg_write(1, 0, 32'h0050_0002);
    cfg_write(0, 1, 80); cfg_write(0, 2, 1); cfg_write(0, 3, 32'h2000); cfg_write(0, 0, 32'h0050_0002);
    do_xfer(5, 0, 50, "R3");
    do_xfer(9, 0, 20, "R3");            // no matching tag
    cfg_write(5, 0, 32'h0070_0000);     // tag 7 without run
    do_xfer(7, 1, 20, "R9");
    cfg_write(4, 0, 32'h0050_0003);     // stream reset (R8)
    cfg_write(4, 0, 32'h0050_0002);
    pos_base = 64'h8000;
    do_xfer(5, 1, 10, "R8");            // restarts at descriptor 0, offset 0
    do_xfer(5, 1, 0, "R11");            // empty request still completes
    quiet = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule